// File: doc/BRIEF.md
# PCIe Root-Port Capability Register Block

This block holds the configuration registers that describe a PCI Express root port: the PCI Express capability structure (device, link, slot and root register pairs plus their second-generation counterparts) and, optionally, a subsystem-identification capability. Software reaches both through one configuration access port. The port carries a dword address into the 256-byte configuration space, four byte enables, write data, and separate read and write strobes. Addresses that fall outside both structures read as zero, and writes to them are dropped.

Every bit has a fixed policy: read-write, read-only, write-one-to-clear or reserved. A write changes only the read-write bits under enabled bytes. Writing a one clears a write-one-to-clear bit. Read-only bits ignore writes. Reserved bits always read zero. Status events arrive from hardware as one-cycle pulses and latch into sticky bits. Read-only status fields show the live level of their inputs. Control fields drive output ports. The placement of the two structures comes from parameters, or is chosen automatically. The resulting chain pointers, and the capability pointer that the header logic needs, are derived from that placement.

Top module: `rpc_root_cap`

## Requirements
- R1: After a synchronous reset, `cfg_rdata`, every control output and every sticky status bit read zero.
- R2: With both placement parameters at 0, the subsystem structure sits at byte 0x40 and the PCI Express structure at 0x48. If the subsystem structure is disabled, the PCI Express structure sits at 0x40. If only the PCI Express offset is given and it leaves fewer than 8 bytes above 0x40, the subsystem structure goes 60 bytes above it. `hdr_cap_ptr` is the lower of the two offsets.
- R3: The first PCI Express dword reads ID 0x10 in bits [7:0] and the next pointer in bits [15:8]. The next pointer is the subsystem offset when that offset is higher, and 0 otherwise. Bits [19:16] read the version, bits [23:20] read 4 (root port), bit 24 reads slot-implemented, and bit 31 reads 0.
- R4: The first subsystem dword reads ID 0x0D in bits [7:0]. Its bits [15:8] hold the PCI Express offset when that offset is higher, and 0 otherwise. The second subsystem dword reads `{SUBSYS_ID, SUBSYS_VID}`.
- R5: A write updates only the read-write bits within bytes whose enable is set. The control outputs show the new value after the write edge. Read-write masks: device control 0x7FFF, link control 0xCEFB, slot control 0x7FFF, root control 0x1F, device control 2 0xF7FF, link control 2 0xFFFF.
- R6: Read-only capability dwords ignore writes and mask their reserved bits. Device capabilities keeps 0x0000803F, link capabilities keeps 0xFF7BFFFF, device capabilities 2 keeps 0x80FFFFFF and link capabilities 2 keeps 0x81FFFFFE.
- R7: Each status pulse sets a sticky bit: device status [3:0], link status [15:14], slot status 8 and [4:0], root status 16, and link status 2 bits 5 and 15. A written one clears the bit only when its byte is enabled. A written zero has no effect.
- R8: When a hardware set pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Read-only status fields return the live input level at the read. These are device status [5:4], link status [13:0], slot status [7:5], root status [15:0] and 17, and link status 2 bits [14:12], [9:6] and [4:0].
- R10: Dwords outside both structures, and the reserved slot capability 2 and slot control 2 dwords, read zero even after a write of all ones.
- R11: `cfg_rdata` takes the addressed value on the clock edge that samples `cfg_rd` high, and holds it while `cfg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dw | input | CFG_DW_W | Dword address in configuration space |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Registered read data |
| hdr_cap_ptr | output | 8 | Offset of the first capability, for the header |
| dev_err_set | input | 4 | Device error event pulses |
| dev_sta_live | input | 2 | Live device status levels |
| lnk_sta_live | input | 14 | Live link status levels |
| lnk_evt_set | input | 2 | Link event pulses |
| slt_evt_set | input | 6 | Slot event pulses ([5] maps to status bit 8) |
| slt_sta_live | input | 3 | Live slot status levels |
| pme_set | input | 1 | PME status event pulse |
| pme_req_id | input | 16 | Live PME requester ID |
| pme_pending | input | 1 | Live PME pending level |
| lnk2_sta_live | input | 16 | Live link status 2 levels (non read-only bits ignored) |
| lnk2_evt_set | input | 2 | Link status 2 event pulses ([1] to bit 15, [0] to bit 5) |
| dev_ctl | output | 15 | Device control field |
| lnk_ctl | output | 16 | Link control field |
| slt_ctl | output | 15 | Slot control field |
| rt_ctl | output | 5 | Root control field |
| dev_ctl2 | output | 16 | Device control 2 field |
| lnk_ctl2 | output | 16 | Link control 2 field |

## Verification
A read returns its data one clock edge after the strobe is sampled. A write changes the control outputs on the edge that samples it. A status pulse becomes visible to a read issued on the next cycle. The bench drives each strobe and pulse on a falling edge and removes it on the following falling edge. It samples `cfg_rdata` and the control outputs at that second falling edge, a half cycle after the register edge, so every expected value is compared in the first cycle it is due. The hold check waits several idle cycles while status changes underneath and then compares against the earlier read.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  localparam int NDW        = 15;       // dwords in the PCI Express structure
  localparam int CAP_BYTES  = NDW * 4;  // 60
  localparam int SSID_BYTES = 8;
  localparam int HDR_END    = 'h40;     // first byte after the standard header
  localparam int IDXW       = 4;

  typedef struct packed {
    logic [31:0] ro;
    logic [31:0] rw;
    logic [31:0] w1c;
  } pol_t;

  // dword order inside the PCI Express structure; software decodes these offsets
  typedef enum logic [IDXW-1:0] {
    DW_HDR, DW_DEVCAP, DW_DEVCS, DW_LNKCAP, DW_LNKCS, DW_SLTCAP, DW_SLTCS,
    DW_RTCC, DW_RTSTA, DW_DEVCAP2, DW_DEVCS2, DW_LNKCAP2, DW_LNKCS2,
    DW_SLTCAP2, DW_SLTCS2
  } dw_e;

  function automatic pol_t pol(input int idx);
    pol_t p;
    p = '0;
    case (idx)
      0:  p.ro = 32'h7FFF_FFFF;
      1:  p.ro = 32'h0000_803F;
      2:  begin p.rw = 32'h0000_7FFF; p.w1c = 32'h000F_0000; p.ro = 32'h0030_0000; end
      3:  p.ro = 32'hFF7B_FFFF;
      4:  begin p.rw = 32'h0000_CEFB; p.w1c = 32'hC000_0000; p.ro = 32'h3FFF_0000; end
      5:  p.ro = 32'hFFFF_FFFF;
      6:  begin p.rw = 32'h0000_7FFF; p.w1c = 32'h011F_0000; p.ro = 32'h00E0_0000; end
      7:  begin p.rw = 32'h0000_001F; p.ro = 32'h0001_0000; end
      8:  begin p.ro = 32'h0002_FFFF; p.w1c = 32'h0001_0000; end
      9:  p.ro = 32'h80FF_FFFF;
      10: p.rw = 32'h0000_F7FF;
      11: p.ro = 32'h81FF_FFFE;
      12: begin p.rw = 32'h0000_FFFF; p.w1c = 32'h8020_0000; p.ro = 32'h73DF_0000; end
      default: ;
    endcase
    return p;
  endfunction

  function automatic int place_ssid(input bit en, input int s, input int p);
    if (!en) return 0;
    if (s != 0) return s;
    if (p == 0) return HDR_END;
    if (p - HDR_END >= SSID_BYTES) return HDR_END;
    return p + CAP_BYTES;
  endfunction

  function automatic int place_pcie(input bit en, input int s, input int p);
    if (p != 0) return p;
    if (!en) return HDR_END;
    if (s == 0) return HDR_END + SSID_BYTES;
    if (s - HDR_END >= CAP_BYTES) return HDR_END;
    return s + SSID_BYTES;
  endfunction

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/rpc_addr_dec.sv
module rpc_addr_dec
  import rpc_pkg::*;
#(
  parameter int AW      = 6,
  parameter bit SSID_EN = 1'b1,
  parameter int SSID_AT = 'h40,
  parameter int PCIE_AT = 'h48
) (
  input  logic [AW-1:0]   cfg_dw,
  output logic            hit_ssid,
  output logic            hit_pcie,
  output logic [IDXW-1:0] pcie_idx,
  output logic            ssid_idx
);
  localparam int P0 = PCIE_AT / 4;
  localparam int P1 = P0 + NDW;
  localparam int S0 = SSID_AT / 4;
  localparam int S1 = S0 + SSID_BYTES / 4;

  assign hit_pcie = (cfg_dw >= AW'(P0)) && (cfg_dw < AW'(P1));
  assign pcie_idx = IDXW'(cfg_dw - AW'(P0));

  generate
    if (SSID_EN) begin : g_ssid
      assign hit_ssid = (cfg_dw >= AW'(S0)) && (cfg_dw < AW'(S1));
      assign ssid_idx = 1'(cfg_dw - AW'(S0));
    end else begin : g_nossid
      assign hit_ssid = 1'b0;
      assign ssid_idx = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rpc_ssid_cap.sv
module rpc_ssid_cap #(
  parameter logic [7:0]  NEXT_PTR   = 8'h00,
  parameter logic [15:0] SUBSYS_VID = 16'h0000,
  parameter logic [15:0] SUBSYS_ID  = 16'h0000
) (
  input  logic        idx,
  output logic [31:0] word
);
  assign word = idx ? {SUBSYS_ID, SUBSYS_VID} : {16'h0000, NEXT_PTR, 8'h0D};
endmodule

// File: rtl/rpc_pcie_cap.sv
module rpc_pcie_cap
  import rpc_pkg::*;
#(
  parameter logic [7:0]  NEXT_PTR    = 8'h00,
  parameter logic [3:0]  CAP_VER     = 4'h2,
  parameter bit          SLOT_IMPL   = 1'b1,
  parameter logic [4:0]  MSG_NUM     = 5'd0,
  parameter bit          RTCAP_VIS   = 1'b0,
  parameter logic [31:0] DEVCAP_VAL  = 32'h0,
  parameter logic [31:0] LNKCAP_VAL  = 32'h0,
  parameter logic [31:0] SLTCAP_VAL  = 32'h0,
  parameter logic [31:0] DEVCAP2_VAL = 32'h0,
  parameter logic [31:0] LNKCAP2_VAL = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [3:0]      be,
  input  logic [31:0]     wdata,
  input  logic [3:0]      dev_err_set,
  input  logic [1:0]      dev_sta_live,
  input  logic [13:0]     lnk_sta_live,
  input  logic [1:0]      lnk_evt_set,
  input  logic [5:0]      slt_evt_set,
  input  logic [2:0]      slt_sta_live,
  input  logic            pme_set,
  input  logic [15:0]     pme_req_id,
  input  logic            pme_pending,
  input  logic [15:0]     lnk2_sta_live,
  input  logic [1:0]      lnk2_evt_set,
  output logic [31:0]     rd_word,
  output logic [14:0]     dev_ctl,
  output logic [15:0]     lnk_ctl,
  output logic [14:0]     slt_ctl,
  output logic [4:0]      rt_ctl,
  output logic [15:0]     dev_ctl2,
  output logic [15:0]     lnk_ctl2
);
  localparam int NSLOT = 1 << IDXW;

  logic [31:0] ro_vec  [NDW];
  logic [31:0] set_vec [NDW];
  logic [31:0] word    [NSLOT];
  logic [31:0] bm;

  assign bm = be_mask(be);

  // live read-only levels, placed at their bit positions
  always_comb begin
    for (int k = 0; k < NDW; k++) ro_vec[k] = '0;
    ro_vec[DW_HDR]     = {2'b00, MSG_NUM, SLOT_IMPL, 4'h4, CAP_VER, NEXT_PTR, 8'h10};
    ro_vec[DW_DEVCAP]  = DEVCAP_VAL;
    ro_vec[DW_DEVCS]   = {10'd0, dev_sta_live, 20'd0};
    ro_vec[DW_LNKCAP]  = LNKCAP_VAL;
    ro_vec[DW_LNKCS]   = {2'b00, lnk_sta_live, 16'd0};
    ro_vec[DW_SLTCAP]  = SLTCAP_VAL;
    ro_vec[DW_SLTCS]   = {8'd0, slt_sta_live, 21'd0};
    ro_vec[DW_RTCC]    = {15'd0, RTCAP_VIS, 16'd0};
    ro_vec[DW_RTSTA]   = {14'd0, pme_pending, 1'b0, pme_req_id};
    ro_vec[DW_DEVCAP2] = DEVCAP2_VAL;
    ro_vec[DW_LNKCAP2] = LNKCAP2_VAL;
    ro_vec[DW_LNKCS2]  = {lnk2_sta_live, 16'd0};
  end

  // hardware set pulses, placed at their sticky bit positions
  always_comb begin
    for (int k = 0; k < NDW; k++) set_vec[k] = '0;
    set_vec[DW_DEVCS]  = {12'd0, dev_err_set, 16'd0};
    set_vec[DW_LNKCS]  = {lnk_evt_set, 30'd0};
    set_vec[DW_SLTCS]  = {7'd0, slt_evt_set[5], 3'd0, slt_evt_set[4:0], 16'd0};
    set_vec[DW_RTSTA]  = {15'd0, pme_set, 16'd0};
    set_vec[DW_LNKCS2] = {lnk2_evt_set[1], 9'd0, lnk2_evt_set[0], 5'd0, 16'd0};
  end

  generate
    for (genvar i = 0; i < NDW; i++) begin : g_dw
      localparam pol_t P = pol(i);
      logic [31:0] rw_q;
      logic [31:0] st_q;
      logic        sel;
      logic [31:0] clr;

      assign sel = wr_en && (idx == IDXW'(i));
      assign clr = sel ? (wdata & P.w1c & bm) : 32'h0;

      always_ff @(posedge clk) begin
        if (rst) begin
          rw_q <= '0;
          st_q <= '0;
        end else begin
          if (sel) rw_q <= (rw_q & ~(P.rw & bm)) | (wdata & P.rw & bm);
          // a set pulse overrides a clear in the same cycle
          st_q <= ((st_q & ~clr) | set_vec[i]) & P.w1c;
        end
      end

      assign word[i] = (rw_q & P.rw) | (st_q & P.w1c) | (ro_vec[i] & P.ro);
    end
    for (genvar j = NDW; j < NSLOT; j++) begin : g_pad
      assign word[j] = '0;
    end
  endgenerate

  assign rd_word  = word[idx];
  assign dev_ctl  = g_dw[DW_DEVCS].rw_q[14:0];
  assign lnk_ctl  = g_dw[DW_LNKCS].rw_q[15:0];
  assign slt_ctl  = g_dw[DW_SLTCS].rw_q[14:0];
  assign rt_ctl   = g_dw[DW_RTCC].rw_q[4:0];
  assign dev_ctl2 = g_dw[DW_DEVCS2].rw_q[15:0];
  assign lnk_ctl2 = g_dw[DW_LNKCS2].rw_q[15:0];
endmodule

// File: rtl/rpc_root_cap.sv
module rpc_root_cap
  import rpc_pkg::*;
#(
  parameter int          CFG_DW_W    = 6,
  parameter bit          SSID_EN     = 1'b1,
  parameter int          SSID_OFS    = 0,
  parameter int          PCIE_OFS    = 0,
  parameter logic [15:0] SUBSYS_VID  = 16'h0000,
  parameter logic [15:0] SUBSYS_ID   = 16'h0000,
  parameter logic [3:0]  CAP_VER     = 4'h2,
  parameter bit          SLOT_IMPL   = 1'b1,
  parameter logic [4:0]  MSG_NUM     = 5'd0,
  parameter bit          RTCAP_VIS   = 1'b0,
  parameter logic [31:0] DEVCAP_VAL  = 32'h0,
  parameter logic [31:0] LNKCAP_VAL  = 32'h0,
  parameter logic [31:0] SLTCAP_VAL  = 32'h0,
  parameter logic [31:0] DEVCAP2_VAL = 32'h0,
  parameter logic [31:0] LNKCAP2_VAL = 32'h0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_DW_W-1:0] cfg_dw,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  output logic [31:0]         cfg_rdata,
  output logic [7:0]          hdr_cap_ptr,
  input  logic [3:0]          dev_err_set,
  input  logic [1:0]          dev_sta_live,
  input  logic [13:0]         lnk_sta_live,
  input  logic [1:0]          lnk_evt_set,
  input  logic [5:0]          slt_evt_set,
  input  logic [2:0]          slt_sta_live,
  input  logic                pme_set,
  input  logic [15:0]         pme_req_id,
  input  logic                pme_pending,
  input  logic [15:0]         lnk2_sta_live,
  input  logic [1:0]          lnk2_evt_set,
  output logic [14:0]         dev_ctl,
  output logic [15:0]         lnk_ctl,
  output logic [14:0]         slt_ctl,
  output logic [4:0]          rt_ctl,
  output logic [15:0]         dev_ctl2,
  output logic [15:0]         lnk_ctl2
);
  localparam int SSID_AT   = place_ssid(SSID_EN, SSID_OFS, PCIE_OFS);
  localparam int PCIE_AT   = place_pcie(SSID_EN, SSID_OFS, PCIE_OFS);
  localparam int CAP_PTR   = (SSID_EN && SSID_AT < PCIE_AT) ? SSID_AT : PCIE_AT;
  localparam int PCIE_NEXT = (SSID_EN && SSID_AT > PCIE_AT) ? SSID_AT : 0;
  localparam int SSID_NEXT = (PCIE_AT > SSID_AT) ? PCIE_AT : 0;

  logic            hit_ssid, hit_pcie, ssid_idx;
  logic [IDXW-1:0] pcie_idx;
  logic [31:0]     pcie_word, ssid_word;

  assign hdr_cap_ptr = 8'(CAP_PTR);

  rpc_addr_dec #(
    .AW(CFG_DW_W), .SSID_EN(SSID_EN), .SSID_AT(SSID_AT), .PCIE_AT(PCIE_AT)
  ) u_dec (
    .cfg_dw(cfg_dw), .hit_ssid(hit_ssid), .hit_pcie(hit_pcie),
    .pcie_idx(pcie_idx), .ssid_idx(ssid_idx)
  );

  rpc_ssid_cap #(
    .NEXT_PTR(8'(SSID_NEXT)), .SUBSYS_VID(SUBSYS_VID), .SUBSYS_ID(SUBSYS_ID)
  ) u_ssid (
    .idx(ssid_idx), .word(ssid_word)
  );

  rpc_pcie_cap #(
    .NEXT_PTR(8'(PCIE_NEXT)), .CAP_VER(CAP_VER), .SLOT_IMPL(SLOT_IMPL),
    .MSG_NUM(MSG_NUM), .RTCAP_VIS(RTCAP_VIS), .DEVCAP_VAL(DEVCAP_VAL),
    .LNKCAP_VAL(LNKCAP_VAL), .SLTCAP_VAL(SLTCAP_VAL),
    .DEVCAP2_VAL(DEVCAP2_VAL), .LNKCAP2_VAL(LNKCAP2_VAL)
  ) u_pcie (
    .clk(clk), .rst(rst), .wr_en(cfg_wr && hit_pcie), .idx(pcie_idx),
    .be(cfg_be), .wdata(cfg_wdata),
    .dev_err_set(dev_err_set), .dev_sta_live(dev_sta_live),
    .lnk_sta_live(lnk_sta_live), .lnk_evt_set(lnk_evt_set),
    .slt_evt_set(slt_evt_set), .slt_sta_live(slt_sta_live),
    .pme_set(pme_set), .pme_req_id(pme_req_id), .pme_pending(pme_pending),
    .lnk2_sta_live(lnk2_sta_live), .lnk2_evt_set(lnk2_evt_set),
    .rd_word(pcie_word), .dev_ctl(dev_ctl), .lnk_ctl(lnk_ctl),
    .slt_ctl(slt_ctl), .rt_ctl(rt_ctl), .dev_ctl2(dev_ctl2), .lnk_ctl2(lnk_ctl2)
  );

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= hit_pcie ? pcie_word : (hit_ssid ? ssid_word : 32'h0);
  end
endmodule

// File: rtl/rpc_root_cap_chk.sv
module rpc_root_cap_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] cfg_dw,
  input logic          cfg_wr,
  input logic          cfg_rd,
  input logic [31:0]   cfg_rdata,
  input logic [14:0]   dev_ctl,
  input logic [15:0]   lnk_ctl,
  input logic [14:0]   slt_ctl,
  input logic [4:0]    rt_ctl,
  input logic [15:0]   dev_ctl2
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: first edge after reset release sees cleared outputs
  always @(posedge clk) begin
    if (rst_q && !rst) begin
      a_r1_reset_clears: assert (cfg_rdata == 32'h0 && dev_ctl == 15'h0 &&
                                 lnk_ctl == 16'h0 && slt_ctl == 15'h0 &&
                                 rt_ctl == 5'h0 && dev_ctl2 == 16'h0);
    end
  end

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> $stable(cfg_rdata));

  a_r10_header_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_dw < AW'(16)) |=> (cfg_rdata == 32'h0));

  a_r5_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> ($stable(dev_ctl) && $stable(lnk_ctl) && $stable(slt_ctl) &&
                 $stable(rt_ctl) && $stable(dev_ctl2)));

  a_r6_lnk_ctl_rsvd: assert property (@(posedge clk) disable iff (rst)
    ((lnk_ctl & 16'h3104) == 16'h0));

  a_r6_dev_ctl2_rsvd: assert property (@(posedge clk) disable iff (rst)
    (dev_ctl2[11] == 1'b0));
endmodule

bind rpc_root_cap rpc_root_cap_chk #(.AW(CFG_DW_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_dw(cfg_dw), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_rdata(cfg_rdata), .dev_ctl(dev_ctl), .lnk_ctl(lnk_ctl),
  .slt_ctl(slt_ctl), .rt_ctl(rt_ctl), .dev_ctl2(dev_ctl2)
);

// File: tb/tb_rpc_root_cap.sv
`timescale 1ns/1ps
module tb_rpc_root_cap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [3:0]  dev_err_set = '0;
  logic [1:0]  dev_sta_live = '0;
  logic [13:0] lnk_sta_live = '0;
  logic [1:0]  lnk_evt_set = '0;
  logic [5:0]  slt_evt_set = '0;
  logic [2:0]  slt_sta_live = '0;
  logic        pme_set = 1'b0;
  logic [15:0] pme_req_id = '0;
  logic        pme_pending = 1'b0;
  logic [15:0] lnk2_sta_live = '0;
  logic [1:0]  lnk2_evt_set = '0;

  logic [31:0] rdata, rdata2;
  logic [7:0]  cap_ptr, cap_ptr2;
  logic [14:0] dev_ctl, slt_ctl, dev_ctl_b, slt_ctl_b;
  logic [15:0] lnk_ctl, dev_ctl2, lnk_ctl2, lnk_ctl_b, dev_ctl2_b, lnk_ctl2_b;
  logic [4:0]  rt_ctl, rt_ctl_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  rpc_root_cap #(
    .SUBSYS_VID(16'h1ABC), .SUBSYS_ID(16'h5DEF), .RTCAP_VIS(1'b1),
    .DEVCAP_VAL(32'hFFFF_FFFF), .LNKCAP_VAL(32'hFFFF_FFFF),
    .SLTCAP_VAL(32'hFFFF_FFFF), .DEVCAP2_VAL(32'hFFFF_FFFF),
    .LNKCAP2_VAL(32'hFFFF_FFFF)
  ) dut (
    .clk(clk), .rst(rst), .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(rdata), .hdr_cap_ptr(cap_ptr),
    .dev_err_set(dev_err_set), .dev_sta_live(dev_sta_live),
    .lnk_sta_live(lnk_sta_live), .lnk_evt_set(lnk_evt_set),
    .slt_evt_set(slt_evt_set), .slt_sta_live(slt_sta_live), .pme_set(pme_set),
    .pme_req_id(pme_req_id), .pme_pending(pme_pending),
    .lnk2_sta_live(lnk2_sta_live), .lnk2_evt_set(lnk2_evt_set),
    .dev_ctl(dev_ctl), .lnk_ctl(lnk_ctl), .slt_ctl(slt_ctl), .rt_ctl(rt_ctl),
    .dev_ctl2(dev_ctl2), .lnk_ctl2(lnk_ctl2)
  );

  // second placement: PCI Express pinned at 0x40, subsystem placed automatically
  rpc_root_cap #(
    .PCIE_OFS('h40), .SUBSYS_VID(16'h1ABC), .SUBSYS_ID(16'h5DEF)
  ) dut2 (
    .clk(clk), .rst(rst), .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(rdata2), .hdr_cap_ptr(cap_ptr2),
    .dev_err_set(dev_err_set), .dev_sta_live(dev_sta_live),
    .lnk_sta_live(lnk_sta_live), .lnk_evt_set(lnk_evt_set),
    .slt_evt_set(slt_evt_set), .slt_sta_live(slt_sta_live), .pme_set(pme_set),
    .pme_req_id(pme_req_id), .pme_pending(pme_pending),
    .lnk2_sta_live(lnk2_sta_live), .lnk2_evt_set(lnk2_evt_set),
    .dev_ctl(dev_ctl_b), .lnk_ctl(lnk_ctl_b), .slt_ctl(slt_ctl_b), .rt_ctl(rt_ctl_b),
    .dev_ctl2(dev_ctl2_b), .lnk_ctl2(lnk_ctl2_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk); cfg_dw = a; cfg_rd = 1'b1;
    @(negedge clk); cfg_rd = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); cfg_dw = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    rd(a);
    check(req, rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 rdata", rdata, 32'h0);
    check("R1 ctl", {dev_ctl, lnk_ctl[0], slt_ctl, rt_ctl}, 36'h0);
    check("R1 ctl2", {dev_ctl2, lnk_ctl2}, 32'h0);
    rd_chk("R1 devstatus", 6'h14, 32'h0);
    rd_chk("R1 rootstatus", 6'h1A, 32'h0);
  endtask

  task automatic t_placement;
    check("R2 cap ptr auto", {24'h0, cap_ptr}, 32'h40);
    check("R2 cap ptr pinned", {24'h0, cap_ptr2}, 32'h40);
    rd(6'h10); check("R3 pinned pcie hdr", rdata2, 32'h0142_7C10);
    rd(6'h1F); check("R4 moved ssid hdr", rdata2, 32'h0000_000D);
    rd(6'h20); check("R4 moved ssid ids", rdata2, 32'h5DEF_1ABC);
  endtask

  task automatic t_headers;
    rd_chk("R3 pcie hdr", 6'h12, 32'h0142_0010);
    rd_chk("R4 ssid hdr", 6'h10, 32'h0000_480D);
    rd_chk("R4 ssid ids", 6'h11, 32'h5DEF_1ABC);
  endtask

  task automatic t_ro_caps;
    rd_chk("R6 devcap", 6'h13, 32'h0000_803F);
    rd_chk("R6 lnkcap", 6'h15, 32'hFF7B_FFFF);
    rd_chk("R6 sltcap", 6'h17, 32'hFFFF_FFFF);
    rd_chk("R6 devcap2", 6'h1B, 32'h80FF_FFFF);
    rd_chk("R6 lnkcap2", 6'h1D, 32'h81FF_FFFE);
    wr(6'h13, 32'h0, 4'hF);
    wr(6'h12, 32'h0, 4'hF);
    rd_chk("R6 devcap after write", 6'h13, 32'h0000_803F);
    rd_chk("R3 hdr after write", 6'h12, 32'h0142_0010);
  endtask

  task automatic t_rw;
    wr(6'h14, 32'hFFFF_FFFF, 4'hF);
    check("R5 dev_ctl all", {17'h0, dev_ctl}, 32'h7FFF);
    wr(6'h14, 32'h0, 4'b0001);
    check("R5 dev_ctl byte0", {17'h0, dev_ctl}, 32'h7F00);
    rd_chk("R5 devctl read", 6'h14, 32'h0000_7F00);
    wr(6'h16, 32'hFFFF_FFFF, 4'hF);
    check("R5 lnk_ctl", {16'h0, lnk_ctl}, 32'hCEFB);
    wr(6'h1C, 32'hFFFF_FFFF, 4'hF);
    check("R5 dev_ctl2", {16'h0, dev_ctl2}, 32'hF7FF);
    rd_chk("R5 devctl2 read", 6'h1C, 32'h0000_F7FF);
    wr(6'h1E, 32'hFFFF_FFFF, 4'hF);
    check("R5 lnk_ctl2", {16'h0, lnk_ctl2}, 32'hFFFF);
    wr(6'h19, 32'hFFFF_FFFF, 4'hF);
    check("R5 rt_ctl", {27'h0, rt_ctl}, 32'h1F);
    rd_chk("R5 rootctl read", 6'h19, 32'h0001_001F);
  endtask

  task automatic t_w1c;
    @(negedge clk); dev_err_set = 4'b1010;
    @(negedge clk); dev_err_set = 4'b0000;
    rd_chk("R7 dev status set", 6'h14, 32'h000A_7F00);
    wr(6'h14, 32'h0008_0000, 4'b0100);
    rd_chk("R7 dev status clear one", 6'h14, 32'h0002_7F00);
    wr(6'h14, 32'h000F_7F00, 4'b0011);
    rd_chk("R7 clear without byte enable", 6'h14, 32'h0002_7F00);
    wr(6'h14, 32'h0000_7F00, 4'hF);
    rd_chk("R7 write zero no effect", 6'h14, 32'h0002_7F00);
    @(negedge clk); lnk_evt_set = 2'b11; lnk_sta_live = 14'h1234;
    @(negedge clk); lnk_evt_set = 2'b00;
    rd_chk("R7 link status", 6'h16, 32'hD234_CEFB);
    wr(6'h16, 32'h4000_0000, 4'b1000);
    rd_chk("R7 link status clear", 6'h16, 32'h9234_CEFB);
    @(negedge clk); slt_evt_set = 6'b100001; slt_sta_live = 3'b101;
    @(negedge clk); slt_evt_set = 6'b0;
    rd_chk("R7 slot status", 6'h18, 32'h01A1_0000);
    wr(6'h18, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R7 slot status clear", 6'h18, 32'h00A0_7FFF);
    check("R5 slt_ctl", {17'h0, slt_ctl}, 32'h7FFF);
    @(negedge clk); pme_set = 1'b1; pme_req_id = 16'hBEEF; pme_pending = 1'b1;
    @(negedge clk); pme_set = 1'b0;
    rd_chk("R7 root status", 6'h1A, 32'h0003_BEEF);
    wr(6'h1A, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R7 root status clear", 6'h1A, 32'h0002_BEEF);
    @(negedge clk); lnk2_evt_set = 2'b11; lnk2_sta_live = 16'hFFFF;
    @(negedge clk); lnk2_evt_set = 2'b00;
    rd_chk("R7 link2 status", 6'h1E, 32'hF3FF_FFFF);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    cfg_dw = 6'h14; cfg_wdata = 32'h0002_0000; cfg_be = 4'b0100; cfg_wr = 1'b1;
    dev_err_set = 4'b0010;
    @(negedge clk); cfg_wr = 1'b0; dev_err_set = 4'b0000;
    rd_chk("R8 set beats clear", 6'h14, 32'h0002_7F00);
    wr(6'h14, 32'h0002_0000, 4'b0100);
    rd_chk("R8 later clear works", 6'h14, 32'h0000_7F00);
  endtask

  task automatic t_live;
    dev_sta_live = 2'b11;
    rd_chk("R9 dev live", 6'h14, 32'h0030_7F00);
    dev_sta_live = 2'b01;
    rd_chk("R9 dev live change", 6'h14, 32'h0010_7F00);
    lnk_sta_live = 14'h0001;
    rd_chk("R9 link live", 6'h16, 32'h8001_CEFB);
  endtask

  task automatic t_outside;
    rd_chk("R10 header area", 6'h05, 32'h0);
    wr(6'h21, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R10 beyond caps", 6'h21, 32'h0);
    wr(6'h1F, 32'hFFFF_FFFF, 4'hF);
    wr(6'h20, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R10 sltcap2", 6'h1F, 32'h0);
    rd_chk("R10 sltctl2", 6'h20, 32'h0);
  endtask

  task automatic t_hold;
    rd(6'h14);
    check("R11 read value", rdata, 32'h0010_7F00);
    @(negedge clk); dev_err_set = 4'b0001; dev_sta_live = 2'b10;
    @(negedge clk); dev_err_set = 4'b0000;
    repeat (3) @(negedge clk);
    check("R11 held while idle", rdata, 32'h0010_7F00);
    rd_chk("R11 new read", 6'h14, 32'h0021_7F00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_placement();
    t_headers();
    t_ro_caps();
    t_rw();
    t_w1c();
    t_set_wins();
    t_live();
    t_outside();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule